// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the bus-facing register file for a three-channel interval timer. A synchronous host port decodes a 2-bit address. Addresses 0, 1 and 2 reach the data port of channels 0, 1 and 2. Address 3 takes control words. A control word either sets up one channel or asks for snapshots of the count or status of one or more channels. The counting logic sits outside this block. Each channel supplies its live 16-bit count, its output level and its null-count flag. This block supplies each channel's operating mode and decimal flag, a configuration strobe, and a load strobe carrying a new 16-bit count value.

Counts move over the 8-bit bus one byte at a time. Each channel keeps its own write pointer and read pointer. Each channel also holds a count snapshot and a status snapshot. A snapshot holds its value while the live count keeps moving, and it frees itself once the host has read it out.

Top module: `timer_host_regs`

## Requirements
- R1: After reset, every channel reports mode 0 and decimal flag 0, and no load or config strobe is raised. Every channel starts in low-then-high byte format with both pointers on the low byte and no snapshot held. The output `rdata` is 0 whenever no data-port read is in progress.
- R2: A control word whose bits 7:6 name channel 0, 1 or 2 and whose bits 5:4 are not 00 takes effect one clock later. The named channel's mode becomes bits 3:1, its decimal flag becomes bit 0 and its format becomes bits 5:4, and its config strobe is high for that one clock. Other channels are untouched.
- R3: In format 01 (high byte only), a data write of byte b raises the load strobe one clock later with value {b, 8'h00}. In format 10 (low byte only), the value is {8'h00, b}.
- R4: In format 11 (low then high), the first data write only stores its byte. The second write raises the load strobe one clock later with value {second, first}.
- R5: With no snapshot held, a data read returns a byte of the live count. Format 01 returns the high byte and format 10 the low byte. Format 11 returns the low byte and the high byte on alternate reads.
- R6: A control word with bits 5:4 = 00 and bits 7:6 naming a channel captures that channel's count. Reads then return the captured bytes until the last byte for the format has been read. After that, reads return the live count again.
- R7: A count capture that arrives while an earlier capture of the same channel is still unread is ignored, and the earlier captured value is kept.
- R8: A control word with bits 7:6 = 11 and bit 0 = 0 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. For each selected channel, bit 5 = 0 captures the count and bit 4 = 0 captures status, and each capture is skipped when the same kind of snapshot is already held. When bit 0 = 1, the whole word is ignored.
- R9: The status byte is {output level, null-count flag, format[1:0], mode[2:0], decimal flag}, with bit 7 first. When both snapshots are held, the first read returns status, and the count bytes follow.
- R10: A control word that sets up a channel puts both of that channel's byte pointers back on the low byte.
- R11: A read with chip select low, or a read of address 3, leaves every pointer and snapshot unchanged. If write and read strobes are both high, the cycle is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register address (0-2 data, 3 control) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational during a read |
| ch_mode | output | 9 | Mode of channel n in bits 3n+2:3n |
| ch_bcd | output | 3 | Decimal-count flag per channel |
| cfg_stb | output | 3 | One-clock pulse when a channel is set up |
| load_stb | output | 3 | One-clock pulse carrying a new count |
| load_val | output | 48 | Count for channel n in bits 16n+15:16n |
| live_cnt | input | 48 | Live count from each channel |
| out_lvl | input | 3 | Output level of each channel |
| null_cnt | input | 3 | Null-count flag of each channel |

## Verification
Several cases involve two events on the same channel at nearly the same time, and these are the ones that decide correctness. One case is a count capture arriving after only one byte of an earlier capture has been read, while the live count has already moved; the bench checks that the second byte still comes from the first capture. Another case is a read-back that asks for both status and count on a channel that already holds a count snapshot. The bench checks that status comes out first, that the old count follows, and that the live value appears only after that. A behavioural model updated on every clock predicts `rdata` and the strobes, and the hand-computed values for these orderings are checked as well.

// File: rtl/timer_host_pkg.sv
package timer_host_pkg;
  localparam int NCH    = 3;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 2;

  localparam logic [1:0] FMT_CAP = 2'b00;
  localparam logic [1:0] FMT_HI  = 2'b01;
  localparam logic [1:0] FMT_LO  = 2'b10;
  localparam logic [1:0] FMT_LH  = 2'b11;

  localparam logic [1:0] SEL_READBACK = 2'b11;
endpackage

// File: rtl/tif_ctl_decode.sv
module tif_ctl_decode
  import timer_host_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] ctl_byte,
  output logic [N-1:0]      prog,
  output logic [N-1:0]      cap_cnt,
  output logic [N-1:0]      cap_stat
);
  logic [1:0] sel;
  logic [1:0] fmt;

  assign sel = ctl_byte[7:6];
  assign fmt = ctl_byte[5:4];

  always_comb begin
    prog     = '0;
    cap_cnt  = '0;
    cap_stat = '0;
    if (ctl_wr) begin
      if (sel == SEL_READBACK) begin
        if (!ctl_byte[0]) begin
          for (int i = 0; i < N; i++) begin
            if (ctl_byte[1+i]) begin
              cap_cnt[i]  = !ctl_byte[5];
              cap_stat[i] = !ctl_byte[4];
            end
          end
        end
      end else begin
        for (int i = 0; i < N; i++) begin
          if (sel == 2'(i)) begin
            if (fmt == FMT_CAP) cap_cnt[i] = 1'b1;
            else                prog[i]    = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tif_chan.sv
module tif_chan
  import timer_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              prog,
  input  logic [5:0]        cfg,
  input  logic              cap_cnt,
  input  logic              cap_stat,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [CNT_W-1:0]  live,
  input  logic              out_lvl,
  input  logic              null_flg,
  output logic [MODE_W-1:0] mode,
  output logic              bcd,
  output logic              cfg_stb,
  output logic              ld_stb,
  output logic [CNT_W-1:0]  ld_val,
  output logic              cnt_held,
  output logic              stat_held,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              bcd_q, bcd_d;
  logic [1:0]        fmt_q, fmt_d;
  logic              wptr_q, wptr_d, rptr_q, rptr_d;
  logic [BYTE_W-1:0] low_q, low_d;
  logic              ld_q, ld_d, cfgs_q, cfgs_d;
  logic [CNT_W-1:0]  ldv_q, ldv_d;
  logic              cl_q, cl_d, sl_q, sl_d;
  logic [CNT_W-1:0]  snap_q, snap_d;
  logic [BYTE_W-1:0] st_q, st_d;
  logic              pair_fmt;
  logic [CNT_W-1:0]  src;

  assign pair_fmt = (fmt_q != FMT_HI) && (fmt_q != FMT_LO);
  assign src      = cl_q ? snap_q : live;

  always_comb begin
    mode_d = mode_q; bcd_d = bcd_q; fmt_d = fmt_q;
    wptr_d = wptr_q; rptr_d = rptr_q; low_d = low_q;
    ld_d = 1'b0; ldv_d = ldv_q; cfgs_d = 1'b0;
    cl_d = cl_q; snap_d = snap_q; sl_d = sl_q; st_d = st_q;
    if (prog) begin
      mode_d = cfg[3:1]; bcd_d = cfg[0]; fmt_d = cfg[5:4];
      wptr_d = 1'b0; rptr_d = 1'b0; cfgs_d = 1'b1;
    end
    if (data_wr) begin
      if (fmt_q == FMT_HI) begin
        ld_d = 1'b1; ldv_d = {wbyte, {BYTE_W{1'b0}}};
      end else if (fmt_q == FMT_LO) begin
        ld_d = 1'b1; ldv_d = {{BYTE_W{1'b0}}, wbyte};
      end else if (!wptr_q) begin
        low_d = wbyte; wptr_d = 1'b1;
      end else begin
        ld_d = 1'b1; ldv_d = {wbyte, low_q}; wptr_d = 1'b0;
      end
    end
    if (data_rd) begin
      if (sl_q) begin
        sl_d = 1'b0;
      end else if (pair_fmt) begin
        rptr_d = !rptr_q;
        if (rptr_q) cl_d = 1'b0;
      end else begin
        cl_d = 1'b0;
      end
    end
    if (cap_cnt && !cl_q) begin
      cl_d = 1'b1; snap_d = live;
    end
    if (cap_stat && !sl_q) begin
      sl_d = 1'b1; st_d = {out_lvl, null_flg, fmt_q, mode_q, bcd_q};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; bcd_q <= 1'b0; fmt_q <= FMT_LH;
      wptr_q <= 1'b0; rptr_q <= 1'b0; low_q <= '0;
      ld_q <= 1'b0; ldv_q <= '0; cfgs_q <= 1'b0;
      cl_q <= 1'b0; snap_q <= '0; sl_q <= 1'b0; st_q <= '0;
    end else begin
      mode_q <= mode_d; bcd_q <= bcd_d; fmt_q <= fmt_d;
      wptr_q <= wptr_d; rptr_q <= rptr_d; low_q <= low_d;
      ld_q <= ld_d; ldv_q <= ldv_d; cfgs_q <= cfgs_d;
      cl_q <= cl_d; snap_q <= snap_d; sl_q <= sl_d; st_q <= st_d;
    end
  end

  always_comb begin
    if (sl_q) rd_byte = st_q;
    else if ((fmt_q == FMT_HI) || (pair_fmt && rptr_q)) rd_byte = src[CNT_W-1:BYTE_W];
    else rd_byte = src[BYTE_W-1:0];
  end

  assign mode      = mode_q;
  assign bcd       = bcd_q;
  assign cfg_stb   = cfgs_q;
  assign ld_stb    = ld_q;
  assign ld_val    = ldv_q;
  assign cnt_held  = cl_q;
  assign stat_held = sl_q;

  AST_LOAD_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    ld_q |-> $past(data_wr)); // R3
  AST_CFG_FOLLOWS_PROG: assert property (@(posedge clk) disable iff (!rst_ni)
    cfgs_q |-> $past(prog)); // R2
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(cl_q) && !$past(data_rd)) |-> (cl_q && $stable(snap_q))); // R7
  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_ni)
    (sl_q && data_rd) |=> (!sl_q && $stable(cl_q) && $stable(rptr_q))); // R9
endmodule

// File: rtl/timer_host_regs.sv
module timer_host_regs
  import timer_host_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs,
  input  logic                    rd,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [BYTE_W-1:0]       rdata,
  output logic [NCH*MODE_W-1:0]   ch_mode,
  output logic [NCH-1:0]          ch_bcd,
  output logic [NCH-1:0]          cfg_stb,
  output logic [NCH-1:0]          load_stb,
  output logic [NCH*CNT_W-1:0]    load_val,
  input  logic [NCH*CNT_W-1:0]    live_cnt,
  input  logic [NCH-1:0]          out_lvl,
  input  logic [NCH-1:0]          null_cnt
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NCH);

  logic [1:0]        rst_sync_q;
  logic              rst_i;
  logic              wr_ok, rd_ok, ctl_wr;
  logic [NCH-1:0]    prog, cap_cnt, cap_stat, data_wr, data_rd;
  logic [NCH-1:0]    cnt_held, stat_held;
  logic [BYTE_W-1:0] rd_byte [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign wr_ok  = cs && wr;
  assign rd_ok  = cs && rd && !wr;
  assign ctl_wr = wr_ok && (addr == CTL_ADDR);

  tif_ctl_decode #(.N(NCH)) u_dec (
    .ctl_wr   (ctl_wr),
    .ctl_byte (wdata),
    .prog     (prog),
    .cap_cnt  (cap_cnt),
    .cap_stat (cap_stat)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign data_wr[g] = wr_ok && (addr == ADDR_W'(g));
    assign data_rd[g] = rd_ok && (addr == ADDR_W'(g));

    tif_chan u_ch (
      .clk       (clk),
      .rst_ni    (rst_i),
      .prog      (prog[g]),
      .cfg       (wdata[5:0]),
      .cap_cnt   (cap_cnt[g]),
      .cap_stat  (cap_stat[g]),
      .data_wr   (data_wr[g]),
      .data_rd   (data_rd[g]),
      .wbyte     (wdata),
      .live      (live_cnt[g*CNT_W +: CNT_W]),
      .out_lvl   (out_lvl[g]),
      .null_flg  (null_cnt[g]),
      .mode      (ch_mode[g*MODE_W +: MODE_W]),
      .bcd       (ch_bcd[g]),
      .cfg_stb   (cfg_stb[g]),
      .ld_stb    (load_stb[g]),
      .ld_val    (load_val[g*CNT_W +: CNT_W]),
      .cnt_held  (cnt_held[g]),
      .stat_held (stat_held[g]),
      .rd_byte   (rd_byte[g])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (data_rd[i]) rdata = rd_byte[i];
    end
  end

  AST_RB_BIT0_IGNORED: assert property (@(posedge clk) disable iff (!rst_i)
    (ctl_wr && wdata[7:6] == SEL_READBACK && wdata[0]) |=>
      ($stable(cnt_held) && $stable(stat_held))); // R8
  AST_PROG_ISOLATED: assert property (@(posedge clk) disable iff (!rst_i)
    (ctl_wr && wdata[7:6] == 2'b00 && wdata[5:4] != FMT_CAP) |=>
      $stable(ch_mode[NCH*MODE_W-1:MODE_W])); // R2
  AST_IDLE_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_i)
    (!rd_ok || addr == CTL_ADDR) && !wr_ok |=>
      ($stable(cnt_held) && $stable(stat_held))); // R11
endmodule

// File: tb/timer_host_regs_bench.sv
module timer_host_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs, rd, wr;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd, cfg_stb, load_stb;
  logic [47:0] load_val;
  logic [47:0] live_cnt;
  logic [2:0]  out_lvl, null_cnt;
  logic [15:0] live [3];

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  assign live_cnt = {live[2], live[1], live[0]};

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_host_regs u_timer_host_regs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
    .cfg_stb(cfg_stb), .load_stb(load_stb), .load_val(load_val),
    .live_cnt(live_cnt), .out_lvl(out_lvl), .null_cnt(null_cnt)
  );

  // behavioural reference model
  int m_mode[3], m_bcd[3], m_fmt[3], m_wp[3], m_rp[3], m_low[3];
  int m_cl[3], m_sl[3], m_csnap[3], m_ssnap[3];
  int e_ld[3], e_ldv[3], e_cfg[3];

  function automatic int pair(int c);
    return (m_fmt[c] != 1 && m_fmt[c] != 2) ? 1 : 0;
  endfunction

  function automatic int peek(int c);
    int v;
    if (m_sl[c] != 0) return m_ssnap[c];
    v = (m_cl[c] != 0) ? m_csnap[c] : int'(live[c]);
    if (m_fmt[c] == 1 || (pair(c) != 0 && m_rp[c] != 0)) return (v >> 8) & 255;
    return v & 255;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 3; i++) begin
      m_mode[i] = 0; m_bcd[i] = 0; m_fmt[i] = 3; m_wp[i] = 0; m_rp[i] = 0;
      m_low[i] = 0; m_cl[i] = 0; m_sl[i] = 0; m_csnap[i] = 0; m_ssnap[i] = 0;
      e_ld[i] = 0; e_ldv[i] = 0; e_cfg[i] = 0;
    end
  endtask

  task automatic m_capture(int c, bit cnt, bit st);
    if (cnt && m_cl[c] == 0) begin m_cl[c] = 1; m_csnap[c] = int'(live[c]); end
    if (st && m_sl[c] == 0) begin
      m_sl[c] = 1;
      m_ssnap[c] = (int'(out_lvl[c]) << 7) | (int'(null_cnt[c]) << 6) |
                   (m_fmt[c] << 4) | (m_mode[c] << 1) | m_bcd[c];
    end
  endtask

  task automatic m_step();
    int c;
    for (int i = 0; i < 3; i++) begin e_ld[i] = 0; e_cfg[i] = 0; end
    if (cs && wr) begin
      if (addr == 2'd3) begin
        if (wdata[7:6] == 2'b11) begin
          if (!wdata[0])
            for (int i = 0; i < 3; i++)
              if (wdata[1+i]) m_capture(i, !wdata[5], !wdata[4]);
        end else begin
          c = int'(wdata[7:6]);
          if (wdata[5:4] == 2'b00) m_capture(c, 1'b1, 1'b0);
          else begin
            m_mode[c] = int'(wdata[3:1]); m_bcd[c] = int'(wdata[0]);
            m_fmt[c] = int'(wdata[5:4]); m_wp[c] = 0; m_rp[c] = 0; e_cfg[c] = 1;
          end
        end
      end else begin
        c = int'(addr);
        if (m_fmt[c] == 1) begin e_ld[c] = 1; e_ldv[c] = int'(wdata) << 8; end
        else if (m_fmt[c] == 2) begin e_ld[c] = 1; e_ldv[c] = int'(wdata); end
        else if (m_wp[c] == 0) begin m_low[c] = int'(wdata); m_wp[c] = 1; end
        else begin e_ld[c] = 1; e_ldv[c] = (int'(wdata) << 8) | m_low[c]; m_wp[c] = 0; end
      end
    end else if (cs && rd && addr != 2'd3) begin
      c = int'(addr);
      if (m_sl[c] != 0) m_sl[c] = 0;
      else if (pair(c) != 0) begin
        if (m_rp[c] != 0) begin m_rp[c] = 0; m_cl[c] = 0; end
        else m_rp[c] = 1;
      end else m_cl[c] = 0;
    end
  endtask

  // the design releases reset two clocks after rst_n rises; the bench stays idle meanwhile
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 3; i++) begin
        chk({cur_req, " load_stb"}, int'(load_stb[i]), e_ld[i]);
        if (e_ld[i] != 0) chk({cur_req, " load_val"}, int'(load_val[16*i +: 16]), e_ldv[i]);
        chk({cur_req, " cfg_stb"}, int'(cfg_stb[i]), e_cfg[i]);
        chk({cur_req, " mode"}, int'(ch_mode[3*i +: 3]), m_mode[i]);
        chk({cur_req, " bcd"}, int'(ch_bcd[i]), m_bcd[i]);
      end
      if (cs && rd && !wr && addr != 2'd3) chk({cur_req, " rdata"}, int'(rdata), peek(int'(addr)));
      else chk({cur_req, " rdata idle"}, int'(rdata), 0);
    end
  end

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    cs = 1; wr = 1; rd = 0; addr = a; wdata = d;
    @(posedge clk); #1;
    cs = 0; wr = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d, input logic sel = 1'b1);
    @(posedge clk); #1;
    cs = sel; rd = 1; wr = 0; addr = a;
    @(negedge clk);
    d = rdata;
    @(posedge clk); #1;
    cs = 0; rd = 0;
  endtask

  task automatic set_live(int c, logic [15:0] v);
    @(posedge clk); #1;
    live[c] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++; checks++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] b;
    rst_n = 0; cs = 0; rd = 0; wr = 0; addr = 0; wdata = 0;
    out_lvl = 3'b000; null_cnt = 3'b000;
    live[0] = 16'hBEEF; live[1] = 16'h1357; live[2] = 16'hA0B1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    cur_req = "R1";
    #1;
    chk("R1 modes", int'(ch_mode), 0);
    chk("R1 load_stb", int'(load_stb), 0);
    chk("R1 rdata", int'(rdata), 0);
    bus_rd(2'd0, b); chk("R1 first byte low", int'(b), 'hEF);
    bus_rd(2'd0, b); chk("R5 pair high", int'(b), 'hBE);

    cur_req = "R2";
    bus_wr(2'd3, 8'b01_01_010_1);
    chk("R2 ch1 mode", int'(ch_mode[5:3]), 2);
    chk("R2 ch0 untouched", int'(ch_mode[2:0]), 0);
    bus_wr(2'd3, 8'b10_10_011_0);
    chk("R2 ch2 mode", int'(ch_mode[8:6]), 3);

    cur_req = "R3";
    bus_wr(2'd1, 8'hAB);
    chk("R3 hi-only load", int'(load_val[31:16]), 'hAB00);
    bus_wr(2'd2, 8'h5C);
    chk("R3 lo-only load", int'(load_val[47:32]), 'h005C);

    cur_req = "R4";
    bus_wr(2'd0, 8'h34);
    chk("R4 no load on first", int'(load_stb[0]), 0);
    bus_wr(2'd0, 8'h12);
    chk("R4 pair load", int'(load_val[15:0]), 'h1234);

    cur_req = "R5";
    bus_rd(2'd1, b); chk("R5 hi-only read", int'(b), 'h13);
    bus_rd(2'd2, b); chk("R5 lo-only read", int'(b), 'hB1);

    cur_req = "R6";
    bus_wr(2'd3, 8'b00_00_0000);
    set_live(0, 16'h4321);
    bus_rd(2'd0, b); chk("R6 snap low", int'(b), 'hEF);
    bus_rd(2'd0, b); chk("R6 snap high", int'(b), 'hBE);
    bus_rd(2'd0, b); chk("R6 live after release", int'(b), 'h21);
    bus_rd(2'd0, b);

    cur_req = "R7";
    bus_wr(2'd3, 8'b00_00_0000);
    bus_rd(2'd0, b); chk("R7 snap low", int'(b), 'h21);
    set_live(0, 16'h9988);
    bus_wr(2'd3, 8'b00_00_0000);
    bus_rd(2'd0, b); chk("R7 old high kept", int'(b), 'h43);
    bus_rd(2'd0, b); chk("R7 live low", int'(b), 'h88);
    bus_rd(2'd0, b);

    cur_req = "R8";
    out_lvl = 3'b101; null_cnt = 3'b010;
    bus_wr(2'd3, 8'b11_00_111_1);
    bus_rd(2'd1, b); chk("R8 bit0 set ignored", int'(b), 'h13);
    bus_wr(2'd3, 8'b11_10_0010);
    set_live(0, 16'h0F0F);
    bus_rd(2'd0, b);

    cur_req = "R9";
    chk("R9 status byte ch0", int'(b), 'hB0);
    bus_rd(2'd0, b); chk("R9 live after status", int'(b), 'h0F);
    bus_rd(2'd0, b);
    bus_wr(2'd3, 8'b00_00_0000);
    set_live(0, 16'h7766);
    bus_wr(2'd3, 8'b11_00_1110);
    bus_rd(2'd0, b); chk("R9 status before count", int'(b), 'hB0);
    bus_rd(2'd0, b); chk("R9 old count low", int'(b), 'h0F);
    bus_rd(2'd0, b); chk("R9 old count high", int'(b), 'h0F);
    bus_rd(2'd1, b); chk("R9 status ch1", int'(b), 'h55);
    bus_rd(2'd1, b); chk("R8 ch1 count", int'(b), 'h13);
    bus_rd(2'd2, b); chk("R9 status ch2", int'(b), 'hA6);
    bus_rd(2'd2, b); chk("R8 ch2 count", int'(b), 'hB1);

    cur_req = "R10";
    bus_wr(2'd0, 8'h77);
    bus_wr(2'd3, 8'b00_11_000_0);
    bus_wr(2'd0, 8'hCD);
    bus_wr(2'd0, 8'hAB);
    chk("R10 write pointer reset", int'(load_val[15:0]), 'hABCD);
    bus_rd(2'd0, b);
    bus_wr(2'd3, 8'b00_11_000_0);
    bus_rd(2'd0, b); chk("R10 read pointer reset", int'(b), 'h66);

    cur_req = "R11";
    bus_rd(2'd0, b, 1'b0); chk("R11 deselected read", int'(b), 0);
    bus_rd(2'd3, b); chk("R11 ctl read", int'(b), 0);
    bus_rd(2'd0, b); chk("R11 pointer unmoved", int'(b), 'h77);
    @(posedge clk); #1;
    cs = 1; rd = 1; wr = 1; addr = 2'd1; wdata = 8'h42;
    @(posedge clk); #1;
    cs = 0; rd = 0; wr = 0;
    chk("R11 write wins", int'(load_val[31:16]), 'h4200);

    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule